// File: doc/BRIEF.md
# Panel Bring-Up Command Sequencer

This block brings a small 128x128 TFT panel controller, run at 16 bits per pixel, from power-on to the point where pixel data may be written. A start request begins the run. The block drives the panel's active-low hardware reset line low for a set number of cycles. It then waits a fixed settle time and issues a fixed list of 37 bytes over a byte-wide port. Each byte on that port carries a flag that tells a command byte from a parameter byte.

The port uses a valid/ready handshake, so a serialiser downstream (for example an SPI shifter) can pace the stream. After the software-reset command and after the sleep-exit command, the block holds the stream idle for a millisecond-scale time. That time is counted in clock cycles and derived from a clock-frequency parameter. When the final memory-write command has been accepted, the block raises `done` and stays quiet until the next start request.

Top module: `panel_init_seq`

## Requirements
- R1: After `rstN` is released and before any `start`, `panelRstN` is 1, `outValid` is 0 and `done` is 0.
- R2: `start` sampled high at a clock edge drives `panelRstN` to 0 from that edge for exactly `RST_PULSE_CYC` cycles, then back to 1.
- R3: After `panelRstN` returns to 1, `outValid` stays 0 for exactly `RST_SETTLE_CYC` cycles before the first byte is offered.
- R4: The bytes accepted are, in order: 01; 11; 3A 05; 26 02; 13; B6 FF 06; B1 08 02; B4 07; C0 0A 02; C1 02; C5 50 63; C7 00; 2A 00 00 00 80; 2B 00 00 00 80; 29; 2C. That is 37 bytes (hex), with spaces grouping each command with its parameters.
- R5: `outIsData` is 0 on the first byte of each group in R4 (a command) and 1 on every byte that follows it within the group (a parameter).
- R6: After the 01 byte is accepted, `outValid` is 0 for exactly `LONG_WAIT_MS*CLK_HZ/1000` cycles. After the 11 byte is accepted, it is 0 for exactly `SHORT_WAIT_MS*CLK_HZ/1000` cycles. Between any other two bytes, `outValid` never drops.
- R7: A byte transfers at a clock edge where `outValid` and `outReady` are both 1. While `outValid` is 1 and `outReady` is 0, `outValid`, `outByte` and `outIsData` hold their values into the next cycle.
- R8: `done` is 0 until the 2C byte is accepted and is 1 from the next cycle. While `done` is 1, `outValid` stays 0 and `done` stays 1 until the next `start`.
- R9: `start` restarts the whole run from R2 in any state, including mid-wait and after `done`, and clears `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the block |
| start | input | 1 | Begin (or restart) the bring-up run |
| outReady | input | 1 | Downstream accepts the offered byte |
| outValid | output | 1 | A byte is offered |
| outByte | output | 8 | Offered byte |
| outIsData | output | 1 | 1 = parameter byte, 0 = command byte |
| panelRstN | output | 1 | Active-low hardware reset to the panel |
| done | output | 1 | Whole list accepted |

## Verification
The full run is tried with three downstream ready patterns: always ready, ready every other cycle, and ready one cycle in four. These separate a sequencer that advances on valid alone, or lets its byte change under a stall, from one that honours the handshake. The gap after each byte is measured in every run. This shows the two long waits are placed after the right bytes and have the right lengths, and that stalls never turn into waits. Restarts are issued in the middle of the long wait and after completion, which shows that `start` overrides every state and that `done` clears.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int SEQ_LEN = 37;
  localparam int IDX_W   = $clog2(SEQ_LEN);

  typedef enum logic [1:0] {
    WAIT_NONE  = 2'd0,
    WAIT_LONG  = 2'd1,
    WAIT_SHORT = 2'd2
  } waitKindT;

  typedef enum logic [1:0] {
    CNT_PULSE  = 2'd0,
    CNT_SETTLE = 2'd1,
    CNT_LONG   = 2'd2,
    CNT_SHORT  = 2'd3
  } cntSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic   cntLoad;
    cntSelT cntSel;
    logic   idxClr;
    logic   idxInc;
  } seqCtlT;

  typedef struct packed {
    logic [7:0] val;
    logic       isData;
    waitKindT   waitAfter;
  } seqEntryT;

  function automatic seqEntryT mkCmd(input logic [7:0] v, input waitKindT w);
    seqEntryT e;
    e.val = v; e.isData = 1'b0; e.waitAfter = w;
    return e;
  endfunction

  function automatic seqEntryT mkPrm(input logic [7:0] v);
    seqEntryT e;
    e.val = v; e.isData = 1'b1; e.waitAfter = WAIT_NONE;
    return e;
  endfunction

  // bring-up byte list, order is behaviour
  function automatic seqEntryT seqEntry(input logic [IDX_W-1:0] idx);
    case (idx)
      6'd0:  return mkCmd(8'h01, WAIT_LONG);
      6'd1:  return mkCmd(8'h11, WAIT_SHORT);
      6'd2:  return mkCmd(8'h3A, WAIT_NONE);
      6'd3:  return mkPrm(8'h05);
      6'd4:  return mkCmd(8'h26, WAIT_NONE);
      6'd5:  return mkPrm(8'h02);
      6'd6:  return mkCmd(8'h13, WAIT_NONE);
      6'd7:  return mkCmd(8'hB6, WAIT_NONE);
      6'd8:  return mkPrm(8'hFF);
      6'd9:  return mkPrm(8'h06);
      6'd10: return mkCmd(8'hB1, WAIT_NONE);
      6'd11: return mkPrm(8'h08);
      6'd12: return mkPrm(8'h02);
      6'd13: return mkCmd(8'hB4, WAIT_NONE);
      6'd14: return mkPrm(8'h07);
      6'd15: return mkCmd(8'hC0, WAIT_NONE);
      6'd16: return mkPrm(8'h0A);
      6'd17: return mkPrm(8'h02);
      6'd18: return mkCmd(8'hC1, WAIT_NONE);
      6'd19: return mkPrm(8'h02);
      6'd20: return mkCmd(8'hC5, WAIT_NONE);
      6'd21: return mkPrm(8'h50);
      6'd22: return mkPrm(8'h63);
      6'd23: return mkCmd(8'hC7, WAIT_NONE);
      6'd24: return mkPrm(8'h00);
      6'd25: return mkCmd(8'h2A, WAIT_NONE);
      6'd26: return mkPrm(8'h00);
      6'd27: return mkPrm(8'h00);
      6'd28: return mkPrm(8'h00);
      6'd29: return mkPrm(8'h80);
      6'd30: return mkCmd(8'h2B, WAIT_NONE);
      6'd31: return mkPrm(8'h00);
      6'd32: return mkPrm(8'h00);
      6'd33: return mkPrm(8'h00);
      6'd34: return mkPrm(8'h80);
      6'd35: return mkCmd(8'h29, WAIT_NONE);
      6'd36: return mkCmd(8'h2C, WAIT_NONE);
      default: return mkCmd(8'h00, WAIT_NONE);
    endcase
  endfunction

endpackage

// File: rtl/panel_seq_datapath.sv
module panel_seq_datapath
  import panel_seq_pkg::*;
#(
  parameter int CLK_HZ         = 125_000_000,
  parameter int LONG_WAIT_MS   = 500,
  parameter int SHORT_WAIT_MS  = 5,
  parameter int RST_PULSE_CYC  = 1250,
  parameter int RST_SETTLE_CYC = 1250
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqCtlT     ctl,
  output logic       cntZero,
  output logic [7:0] curByte,
  output logic       curIsData,
  output waitKindT   curWait,
  output logic       curLast
);

  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int LONG_CYC   = LONG_WAIT_MS * CYC_PER_MS;
  localparam int SHORT_CYC  = SHORT_WAIT_MS * CYC_PER_MS;
  localparam int MAX_A      = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int MAX_B      = (RST_PULSE_CYC > RST_SETTLE_CYC) ? RST_PULSE_CYC : RST_SETTLE_CYC;
  localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic [IDX_W-1:0] idx;
  seqEntryT         entry;

  always_comb begin
    case (ctl.cntSel)
      CNT_PULSE:  loadVal = CNT_W'(RST_PULSE_CYC - 1);
      CNT_SETTLE: loadVal = CNT_W'(RST_SETTLE_CYC - 1);
      CNT_LONG:   loadVal = CNT_W'(LONG_CYC - 1);
      default:    loadVal = CNT_W'(SHORT_CYC - 1);
    endcase
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (ctl.cntLoad) cnt <= loadVal;
    else if (!cntZero)    cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idx <= '0;
    else if (ctl.idxClr) idx <= '0;
    else if (ctl.idxInc) idx <= idx + IDX_W'(1);
  end

  assign entry     = seqEntry(idx);
  assign curByte   = entry.val;
  assign curIsData = entry.isData;
  assign curWait   = entry.waitAfter;
  assign curLast   = (idx == IDX_W'(SEQ_LEN - 1));

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    idx < IDX_W'(SEQ_LEN)); // R4
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntZero && !ctl.cntLoad) |=> cntZero); // R6

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     outReady,
  input  logic     cntZero,
  input  waitKindT curWait,
  input  logic     curLast,
  output seqCtlT   ctl,
  output logic     outValid,
  output logic     panelRstN,
  output logic     done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PULSE, ST_SETTLE, ST_SEND, ST_WAIT, ST_DONE
  } stateT;

  stateT state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (start) begin
      nextState  = ST_PULSE;
      ctl.cntLoad = 1'b1;
      ctl.cntSel  = CNT_PULSE;
      ctl.idxClr  = 1'b1;
    end else begin
      case (state)
        ST_PULSE: if (cntZero) begin
          nextState   = ST_SETTLE;
          ctl.cntLoad = 1'b1;
          ctl.cntSel  = CNT_SETTLE;
        end
        ST_SETTLE: if (cntZero) nextState = ST_SEND;
        ST_SEND: if (outReady) begin
          if (curLast) begin
            nextState = ST_DONE;
          end else begin
            ctl.idxInc = 1'b1;
            if (curWait != WAIT_NONE) begin
              nextState   = ST_WAIT;
              ctl.cntLoad = 1'b1;
              ctl.cntSel  = (curWait == WAIT_LONG) ? CNT_LONG : CNT_SHORT;
            end
          end
        end
        ST_WAIT: if (cntZero) nextState = ST_SEND;
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign outValid  = (state == ST_SEND);
  assign panelRstN = (state != ST_PULSE);
  assign done      = (state == ST_DONE);

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !panelRstN |-> !outValid); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R8
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!panelRstN && !done)); // R9

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import panel_seq_pkg::*;
#(
  parameter int CLK_HZ         = 125_000_000,
  parameter int LONG_WAIT_MS   = 500,
  parameter int SHORT_WAIT_MS  = 5,
  parameter int RST_PULSE_CYC  = 1250,
  parameter int RST_SETTLE_CYC = 1250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outByte,
  output logic       outIsData,
  output logic       panelRstN,
  output logic       done
);

  seqCtlT   ctl;
  logic     cntZero;
  waitKindT curWait;
  logic     curLast;

  panel_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .outReady  (outReady),
    .cntZero   (cntZero),
    .curWait   (curWait),
    .curLast   (curLast),
    .ctl       (ctl),
    .outValid  (outValid),
    .panelRstN (panelRstN),
    .done      (done)
  );

  panel_seq_datapath #(
    .CLK_HZ         (CLK_HZ),
    .LONG_WAIT_MS   (LONG_WAIT_MS),
    .SHORT_WAIT_MS  (SHORT_WAIT_MS),
    .RST_PULSE_CYC  (RST_PULSE_CYC),
    .RST_SETTLE_CYC (RST_SETTLE_CYC)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cntZero   (cntZero),
    .curByte   (outByte),
    .curIsData (outIsData),
    .curWait   (curWait),
    .curLast   (curLast)
  );

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !start) |=>
      (outValid && $stable(outByte) && $stable(outIsData))); // R7

endmodule

// File: tb/tb_panel_init_seq.sv
module tb_panel_init_seq;

  localparam int CLK_HZ    = 2000;
  localparam int LONG_MS   = 500;
  localparam int SHORT_MS  = 5;
  localparam int PULSE     = 4;
  localparam int SETTLE    = 6;
  localparam int LONG_CYC  = LONG_MS * CLK_HZ / 1000;
  localparam int SHORT_CYC = SHORT_MS * CLK_HZ / 1000;
  localparam int NBYTES    = 37;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       outReady = 1'b0;
  logic       outValid, outIsData, panelRstN, done;
  logic [7:0] outByte;

  int checks = 0;
  int errors = 0;

  logic [7:0] expByte [NBYTES];
  logic       expData [NBYTES];

  always #4 clk = ~clk;

  panel_init_seq #(
    .CLK_HZ(CLK_HZ), .LONG_WAIT_MS(LONG_MS), .SHORT_WAIT_MS(SHORT_MS),
    .RST_PULSE_CYC(PULSE), .RST_SETTLE_CYC(SETTLE)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .outReady(outReady),
    .outValid(outValid), .outByte(outByte), .outIsData(outIsData),
    .panelRstN(panelRstN), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setExp(input int i, input logic [7:0] b, input logic d);
    expByte[i] = b;
    expData[i] = d;
  endtask

  task automatic buildExp();
    int k = 0;
    setExp(k++, 8'h01, 0); setExp(k++, 8'h11, 0);
    setExp(k++, 8'h3A, 0); setExp(k++, 8'h05, 1);
    setExp(k++, 8'h26, 0); setExp(k++, 8'h02, 1);
    setExp(k++, 8'h13, 0);
    setExp(k++, 8'hB6, 0); setExp(k++, 8'hFF, 1); setExp(k++, 8'h06, 1);
    setExp(k++, 8'hB1, 0); setExp(k++, 8'h08, 1); setExp(k++, 8'h02, 1);
    setExp(k++, 8'hB4, 0); setExp(k++, 8'h07, 1);
    setExp(k++, 8'hC0, 0); setExp(k++, 8'h0A, 1); setExp(k++, 8'h02, 1);
    setExp(k++, 8'hC1, 0); setExp(k++, 8'h02, 1);
    setExp(k++, 8'hC5, 0); setExp(k++, 8'h50, 1); setExp(k++, 8'h63, 1);
    setExp(k++, 8'hC7, 0); setExp(k++, 8'h00, 1);
    setExp(k++, 8'h2A, 0); setExp(k++, 8'h00, 1); setExp(k++, 8'h00, 1);
    setExp(k++, 8'h00, 1); setExp(k++, 8'h80, 1);
    setExp(k++, 8'h2B, 0); setExp(k++, 8'h00, 1); setExp(k++, 8'h00, 1);
    setExp(k++, 8'h00, 1); setExp(k++, 8'h80, 1);
    setExp(k++, 8'h29, 0); setExp(k++, 8'h2C, 0);
  endtask

  function automatic logic readyFor(input int pattern, input int cyc);
    case (pattern)
      0:       return 1'b1;
      1:       return (cyc % 2) == 1;
      default: return (cyc % 4) == 3;
    endcase
  endfunction

  // R1: idle state after reset
  task automatic testReset();
    chk(panelRstN == 1'b1, "R1", "panelRstN after reset", panelRstN, 1);
    chk(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    repeat (10) @(negedge clk);
    chk(outValid == 1'b0 && panelRstN == 1'b1, "R1", "idle without start",
        {outValid, panelRstN}, 1);
  endtask

  // full run with a given ready pattern; start pulsed at a negedge
  task automatic runSeq(input int pattern);
    int lowCnt = 0;
    int settleCnt = 0;
    int idx = 0;
    int bubble = 0;
    int cyc = 0;
    int earlyDone = 0;
    bit holdPend = 0;
    logic [7:0] heldByte = '0;
    logic heldData = 1'b0;
    logic rdy;
    @(negedge clk);
    outReady = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R9", "done cleared by start", done, 0);
    while (!panelRstN) begin
      lowCnt++;
      @(negedge clk);
    end
    chk(lowCnt == PULSE, "R2", "reset pulse width", lowCnt, PULSE);
    while (panelRstN && !outValid) begin
      settleCnt++;
      @(negedge clk);
    end
    chk(settleCnt == SETTLE, "R3", "settle cycles", settleCnt, SETTLE);
    while (idx < NBYTES) begin
      if (done) earlyDone++;
      if (holdPend) begin
        chk(outValid && outByte == heldByte && outIsData == heldData, "R7",
            "byte held under stall", outByte, heldByte);
        holdPend = 0;
      end
      if (!outValid) begin
        outReady = 1'b0;
        bubble++;
      end else begin
        rdy = readyFor(pattern, cyc);
        outReady = rdy;
        if (rdy) begin
          chk(outByte == expByte[idx], "R4", $sformatf("byte %0d", idx),
              outByte, expByte[idx]);
          chk(outIsData == expData[idx], "R5", $sformatf("flag %0d", idx),
              outIsData, expData[idx]);
          chk(bubble == (idx == 1 ? LONG_CYC : (idx == 2 ? SHORT_CYC : 0)),
              "R6", $sformatf("gap before byte %0d", idx), bubble,
              idx == 1 ? LONG_CYC : (idx == 2 ? SHORT_CYC : 0));
          idx++;
          bubble = 0;
        end else begin
          holdPend = 1;
          heldByte = outByte;
          heldData = outIsData;
        end
      end
      cyc++;
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(earlyDone == 0, "R8", "done before last byte", earlyDone, 0);
    chk(done == 1'b1, "R8", "done after last byte", done, 1);
    chk(outValid == 1'b0, "R8", "valid after last byte", outValid, 0);
  endtask

  // R8: quiet and sticky after completion
  task automatic testQuietAfterDone();
    int bad = 0;
    outReady = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (outValid || !done) bad++;
    end
    outReady = 1'b0;
    chk(bad == 0, "R8", "quiet after done", bad, 0);
  endtask

  // R9: restart during the long wait
  task automatic testRestartMidWait();
    @(negedge clk);
    outReady = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (PULSE + SETTLE + 20) @(negedge clk);
    chk(outValid == 1'b0 && panelRstN == 1'b1, "R9", "in long wait before restart",
        {outValid, panelRstN}, 1);
    runSeq(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    buildExp();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runSeq(0);
    testQuietAfterDone();
    runSeq(1);
    runSeq(2);
    testRestartMidWait();
    testQuietAfterDone();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule